// File: doc/BRIEF.md
# Tail-Phase PWM Generator with Wrapping Counter

This block turns a free-running, reloadable up-counter into a pulse-width-modulated output. The counter runs from 0 up to a programmed limit and then wraps back to 0, so one period lasts limit+1 clocks. A separate threshold value picks the duty cycle. The output rises on the clock edge after the counter equals the threshold. It falls on the clock edge after the counter equals the limit, which is the same point where the counter wraps. The high phase therefore sits at the end of each period.

The limit is written with a one-cycle strobe. That write also restarts the counter at 0 and forces the output low. Two control bits from the timer's control word arrive here as single-bit inputs. Control bit 0 (`run_en`) lets the counter advance. Control bit 5 (`pwm_en`) gates the output. A small three-state machine (off, low phase, high phase) holds the output level, and all logic runs in the timer clock domain.

The state machine has three states. ST_OFF holds the output low. ST_LOW is the low phase, which waits for a threshold match. ST_HIGH is the high phase, which waits for the wrap. The transitions are named as follows. T_DISABLE goes from any state to ST_OFF when `pwm_en` is clear, and it has the highest priority. T_RELOAD goes from any state to ST_LOW on a limit write. T_ENABLE goes from ST_OFF to ST_LOW when `pwm_en` is set and no match is due. T_MATCH goes from ST_LOW or ST_OFF to ST_HIGH when the counter equals the threshold and is not at the limit. T_WRAP goes from any running state to ST_LOW when the counter equals the limit. In every other case the state holds.

Top module: `pwm_tail_gen`

## Requirements
- R1: After reset, `count` is 0 and `pwm_out` is low.
- R2: While `run_en` is high and the counter is below the limit, `count` rises by one per clock. While `run_en` is low, `count` holds its value.
- R3: When `count` equals the stored limit and `run_en` is high, `count` becomes 0 on the next edge, so the period is limit+1 clocks. `count` never exceeds the stored limit.
- R4: A cycle with `load_wr` high stores `load_data` as the new limit. On the next edge, `count` is 0 and `pwm_out` is low.
- R5: With `pwm_en` and `run_en` high, `pwm_out` is high on the edge after `count` equals `cmp_val`, provided `count` is not at the limit.
- R6: With `pwm_en` and `run_en` high, `pwm_out` is low on the edge after `count` equals the limit. The high time per period is limit − `cmp_val` clocks.
- R7: With `cmp_val` = 0, the output is high for limit clocks out of every limit+1.
- R8: With `cmp_val` greater than or equal to the limit, the output stays low.
- R9: With `pwm_en` low, `pwm_out` is low on the next edge. After `pwm_en` is set again, the output stays low until the next threshold match.
- R10: With `run_en` low and no limit write, `pwm_out` keeps its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Counter run bit (control bit 0) |
| pwm_en | input | 1 | Output enable bit (control bit 5) |
| load_wr | input | 1 | One-cycle strobe that writes the limit |
| load_data | input | W | New limit value |
| cmp_val | input | W | Threshold value (duty cycle) |
| count | output | W | Current counter value |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The bound checker checks the following on every cycle:
- the single-step advance of the counter, and that it holds while stopped;
- the counter bound and the wrap to 0;
- the reload that clears both the counter and the output;
- the forced-low output while `pwm_en` is off;
- the rise after a threshold match.

Some properties span whole periods, so only the bench's scenarios can show them. These are the exact high-time per period for a middle threshold, for threshold 0 and for out-of-range thresholds, and the resumption after re-enable. The bench's behavioural model also compares `count` and `pwm_out` on every clock across all of these scenarios.

// File: rtl/pwm_tail_pkg.sv
package pwm_tail_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } pwm_state_e;

endpackage

// File: rtl/pwm_tail_cnt.sv
module pwm_tail_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_en,
    input  logic         load_wr,
    input  logic [W-1:0] load_data,
    input  logic         at_limit,
    output logic [W-1:0] count_q,
    output logic [W-1:0] limit_q
);

    localparam logic [W-1:0] ZERO = '0;
    localparam logic [W-1:0] ONE  = W'(1);

    // The limit register changes only on a write strobe.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            limit_q <= ZERO;
        end else if (load_wr) begin
            limit_q <= load_data;
        end
    end

    // The counter restarts on a write, wraps at the limit and advances only while running.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= ZERO;
        end else if (load_wr) begin
            count_q <= ZERO;
        end else if (run_en) begin
            if (at_limit) begin
                count_q <= ZERO;
            end else begin
                count_q <= count_q + ONE;
            end
        end
    end

endmodule

// File: rtl/pwm_tail_match.sv
module pwm_tail_match #(
    parameter int W = 16
) (
    input  logic [W-1:0] count_q,
    input  logic [W-1:0] limit_q,
    input  logic [W-1:0] cmp_val,
    output logic         at_limit,
    output logic         at_cmp
);

    // Equality detectors shared by the counter and the state machine.
    always_comb begin
        at_limit = (count_q == limit_q);
        at_cmp   = (count_q == cmp_val);
    end

endmodule

// File: rtl/pwm_tail_fsm.sv
module pwm_tail_fsm
    import pwm_tail_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_en,
    input  logic run_en,
    input  logic load_wr,
    input  logic at_limit,
    input  logic at_cmp,
    output logic pwm_q
);

    pwm_state_e state_q;
    pwm_state_e state_d;

    // Next-state logic. T_DISABLE has priority over T_RELOAD, and T_WRAP over T_MATCH.
    always_comb begin
        state_d = state_q;
        if (!pwm_en) begin
            state_d = ST_OFF;                     // T_DISABLE
        end else if (load_wr) begin
            state_d = ST_LOW;                     // T_RELOAD
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    if (run_en && at_cmp && !at_limit) begin
                        state_d = ST_HIGH;        // T_MATCH
                    end else begin
                        state_d = ST_LOW;         // T_ENABLE
                    end
                end
                ST_LOW: begin
                    if (run_en && at_cmp && !at_limit) begin
                        state_d = ST_HIGH;        // T_MATCH
                    end
                end
                ST_HIGH: begin
                    if (run_en && at_limit) begin
                        state_d = ST_LOW;         // T_WRAP
                    end
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered output: it follows the state chosen at the same edge, so it is glitch-free.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwm_q <= 1'b0;
        end else begin
            pwm_q <= (state_d == ST_HIGH);
        end
    end

endmodule

// File: rtl/pwm_tail_gen.sv
module pwm_tail_gen #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_en,
    input  logic         pwm_en,
    input  logic         load_wr,
    input  logic [W-1:0] load_data,
    input  logic [W-1:0] cmp_val,
    output logic [W-1:0] count,
    output logic         pwm_out
);

    logic [W-1:0] count_q;
    logic [W-1:0] limit_q;
    logic         at_limit;
    logic         at_cmp;
    logic         pwm_q;

    pwm_tail_cnt #(.W(W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .load_wr   (load_wr),
        .load_data (load_data),
        .at_limit  (at_limit),
        .count_q   (count_q),
        .limit_q   (limit_q)
    );

    pwm_tail_match #(.W(W)) u_match (
        .count_q  (count_q),
        .limit_q  (limit_q),
        .cmp_val  (cmp_val),
        .at_limit (at_limit),
        .at_cmp   (at_cmp)
    );

    pwm_tail_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwm_en   (pwm_en),
        .run_en   (run_en),
        .load_wr  (load_wr),
        .at_limit (at_limit),
        .at_cmp   (at_cmp),
        .pwm_q    (pwm_q)
    );

    assign count   = count_q;
    assign pwm_out = pwm_q;

endmodule

// File: rtl/pwm_tail_chk.sv
module pwm_tail_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         run_en,
    input logic         pwm_en,
    input logic         load_wr,
    input logic [W-1:0] cmp_val,
    input logic [W-1:0] count,
    input logic [W-1:0] limit_q,
    input logic         pwm_out
);

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !load_wr && count != limit_q) |=> (count == W'($past(count) + 1'b1)));

    p_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !load_wr) |=> $stable(count));

    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !load_wr && count == limit_q) |=> (count == '0));

    p_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= limit_q);

    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_wr |=> (count == '0 && !pwm_out));

    p_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_en && run_en && !load_wr && count == cmp_val && count != limit_q) |=> pwm_out);

    p_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !load_wr && count == limit_q) |=> !pwm_out);

    p_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_en |=> !pwm_out);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_en && !run_en && !load_wr) |=> $stable(pwm_out));

endmodule

bind pwm_tail_gen pwm_tail_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_en  (run_en),
    .pwm_en  (pwm_en),
    .load_wr (load_wr),
    .cmp_val (cmp_val),
    .count   (count),
    .limit_q (limit_q),
    .pwm_out (pwm_out)
);

// File: tb/pwm_tail_gen_tb.sv
`timescale 1ns/1ps
module pwm_tail_gen_tb;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         run_en = 1'b0;
    logic         pwm_en = 1'b0;
    logic         load_wr = 1'b0;
    logic [W-1:0] load_data = '0;
    logic [W-1:0] cmp_val = '0;
    logic [W-1:0] count;
    logic         pwm_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference state
    int m_cnt = 0;
    int m_lim = 0;
    int m_pwm = 0;
    int highs = 0;

    always #2 clk = ~clk;

    pwm_tail_gen #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .pwm_en(pwm_en),
        .load_wr(load_wr), .load_data(load_data), .cmp_val(cmp_val),
        .count(count), .pwm_out(pwm_out)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Drives one cycle at the falling edge, advances the model, then compares after the rising edge.
    task automatic step(input bit wr, input int data, input bit run, input bit en, input int cmp);
        string ptag;
        string ctag;
        int n_pwm;
        int n_cnt;
        load_wr = wr; load_data = W'(data); run_en = run; pwm_en = en; cmp_val = W'(cmp);
        n_pwm = m_pwm;
        if (!en) begin n_pwm = 0; ptag = "R9 off"; end
        else if (wr) begin n_pwm = 0; ptag = "R4 reload pwm"; end
        else if (!run) begin ptag = "R10 hold"; end
        else if (m_cnt == m_lim) begin n_pwm = 0; ptag = "R6 fall"; end
        else if (m_cnt == cmp) begin n_pwm = 1; ptag = "R5 rise"; end
        else begin ptag = "R5/R6 level"; end
        n_cnt = m_cnt;
        if (wr) begin n_cnt = 0; m_lim = data; ctag = "R4 reload count"; end
        else if (!run) begin ctag = "R2 stopped"; end
        else if (m_cnt == m_lim) begin n_cnt = 0; ctag = "R3 wrap"; end
        else begin n_cnt = m_cnt + 1; ctag = "R2 step"; end
        m_cnt = n_cnt; m_pwm = n_pwm;
        @(posedge clk);
        @(negedge clk);
        check(ctag, int'(count), m_cnt);
        check(ptag, int'(pwm_out), m_pwm);
        if (pwm_out) highs++;
    endtask

    task automatic run_for(input int n, input int cmp);
        for (int i = 0; i < n; i++) step(0, 0, 1, 1, cmp);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        check("R1 reset count", int'(count), 0);
        check("R1 reset pwm", int'(pwm_out), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Mid threshold: limit 9, threshold 3 -> 6 high clocks per 10
        step(1, 9, 1, 1, 3);
        highs = 0;
        run_for(30, 3);
        check("R6 high time 3 periods", highs, 18);

        // Stop the counter while high, then resume
        run_for(5, 3);
        for (int i = 0; i < 5; i++) step(0, 0, 0, 1, 3);
        run_for(12, 3);

        // Threshold 0: limit 7 -> 7 high clocks per 8
        step(1, 7, 1, 1, 0);
        highs = 0;
        run_for(16, 0);
        check("R7 high time cmp=0", highs, 14);

        // Out-of-range thresholds
        step(1, 7, 1, 1, 12);
        highs = 0;
        run_for(16, 12);
        check("R8 cmp>limit never high", highs, 0);
        step(1, 7, 1, 1, 7);
        highs = 0;
        run_for(16, 7);
        check("R8 cmp==limit never high", highs, 0);

        // Period: limit 5 wraps after 6 steps
        step(1, 5, 1, 1, 2);
        run_for(6, 2);
        check("R3 period limit+1", int'(count), 0);

        // Disable during the high phase, then re-enable mid period
        step(1, 9, 1, 1, 2);
        run_for(5, 2);
        check("R5 high before disable", int'(pwm_out), 1);
        for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 2);
        check("R9 low while disabled", int'(pwm_out), 0);
        step(0, 0, 1, 1, 2);
        check("R9 no resume before match", int'(pwm_out), 0);
        run_for(20, 2);

        // Reload in the high phase
        run_for(4, 2);
        step(1, 9, 1, 1, 2);
        check("R4 reload forces low", int'(pwm_out), 0);
        run_for(10, 2);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule